// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands over several clock cycles, one multiplier bit per clock, using a single double-width accumulator and an adder only as wide as one operand. When a start pulse is accepted, the upper half of the accumulator is cleared and the lower half takes the multiplier. On each following clock, the lowest accumulator bit decides whether the multiplicand is added into the upper half. The whole accumulator then moves right by one place, and the adder's carry enters at the top.

The multiplier bits are consumed from the low end of the accumulator as product bits enter at the high end, so no separate multiplier register is needed. After the last step the accumulator holds the full product, which appears as an upper word and a lower word. A caller pulses start while the block is idle, waits for the one-cycle done pulse, and reads both words. The words stay unchanged until the next accepted start.

Top module: `shiftadd_mul`

## Requirements
- R1: After a synchronous reset, busy_o and done_o are 0 and both hi_o and lo_o are 0.
- R2: A start_i sampled high while busy_o is low is accepted: busy_o is 1 from the next cycle, and the operands sampled on that edge are the ones multiplied.
- R3: On completion, {hi_o, lo_o} equals the full unsigned product of the accepted operands, with hi_o the upper WIDTH bits. This holds for all-ones operands, whose adder carries must not be lost.
- R4: done_o rises exactly WIDTH clock edges after the edge that accepted start, because one multiplier bit is consumed per clock.
- R5: done_o is high for exactly one cycle, and busy_o is low in that cycle.
- R6: While idle and with no new start, hi_o and lo_o keep their values, including in the cycles after done_o.
- R7: A start_i asserted while busy_o is high is ignored: the running operation keeps its operands, result and completion time.
- R8: A start_i given in the same cycle as done_o is accepted and begins a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a multiplication (accepted only while idle) |
| mcand_i | input | WIDTH | Multiplicand, sampled on accepted start |
| mplier_i | input | WIDTH | Multiplier, sampled on accepted start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | WIDTH | Upper half of the product |
| lo_o | output | WIDTH | Lower half of the product |

## Verification
Start is driven on a falling edge, so the rising edge that follows accepts it. From that edge, busy_o is expected at the next falling edge and done_o at the WIDTH+1-th falling edge (the 33rd at the default width), where the product words are compared against a product computed in the bench. The bench counts falling edges from the start pulse instead of waiting without limit, so a completion one cycle early or late is reported as a latency error. The hold checks sample the outputs on the falling edges after done_o, and the ignored-start test drives its stray pulse in the middle of a run and expects the original completion cycle and result.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;
  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_RUN  = 1'b1
  } mul_state_t;
endpackage

// File: rtl/shiftadd_mul_ctrl.sv
module shiftadd_mul_ctrl
  import shiftadd_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mul_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign busy_o = (state_q == MS_RUN);
  assign step_o = busy_o;
  assign load_o = start_i && !busy_o;
  assign done_o = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        MS_IDLE: begin
          if (start_i) begin
            state_q <= MS_RUN;
            cnt_q   <= '0;
          end
        end
        MS_RUN: begin
          if (cnt_q == LAST) begin
            state_q <= MS_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shiftadd_mul_dp.sv
module shiftadd_mul_dp #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    acc_q;
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] addend;

  assign addend = acc_q[0] ? mcand_q : '0;
  assign sum    = {1'b0, acc_q[PW-1:WIDTH]} + {1'b0, addend};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (load_i) begin
      acc_q   <= {{WIDTH{1'b0}}, mplier_i};
      mcand_q <= mcand_i;
    end else if (step_i) begin
      acc_q <= {sum, acc_q[WIDTH-1:1]};
    end
  end

  assign hi_o = acc_q[PW-1:WIDTH];
  assign lo_o = acc_q[WIDTH-1:0];
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  logic load;
  logic step;

  shiftadd_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  shiftadd_mul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .step_i   (step),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .hi_o     (hi_o),
    .lo_o     (lo_o)
  );
endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [WIDTH-1:0] mcand_i,
  input logic [WIDTH-1:0] mplier_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] hi_o,
  input logic [WIDTH-1:0] lo_o
);
  localparam int CW = $clog2(WIDTH + 1) + 1;

  logic [CW-1:0]      run_cnt;
  logic [2*WIDTH-1:0] want_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      want_q  <= '0;
    end else if (start_i && !busy_o) begin
      run_cnt <= '0;
      want_q  <= {{WIDTH{1'b0}}, mcand_i} * {{WIDTH{1'b0}}, mplier_i};
    end else if (busy_o) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R2
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  // R3
  a_r3_product: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ({hi_o, lo_o} == want_q));

  // R4
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (run_cnt == CW'(WIDTH)));

  // R5
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5
  a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> ($stable(hi_o) && $stable(lo_o)));
endmodule

bind shiftadd_mul shiftadd_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .mcand_i  (mcand_i),
  .mplier_i (mplier_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .hi_o     (hi_o),
  .lo_o     (lo_o)
);

// File: tb/shiftadd_mul_bench.sv
module shiftadd_mul_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [W-1:0] mcand_i = '0;
  logic [W-1:0] mplier_i = '0;
  logic         busy_o, done_o;
  logic [W-1:0] hi_o, lo_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  shiftadd_mul #(.WIDTH(W)) u_shiftadd_mul (
    .clk(clk), .rst(rst), .start_i(start_i), .mcand_i(mcand_i),
    .mplier_i(mplier_i), .busy_o(busy_o), .done_o(done_o),
    .hi_o(hi_o), .lo_o(lo_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive start at a falling edge for one cycle; returns at the next falling edge.
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
    start_i  = 1'b1;
    mcand_i  = a;
    mplier_i = b;
    @(negedge clk);
    start_i  = 1'b0;
    mcand_i  = ~a;
    mplier_i = ~b;
  endtask

  // k0: falling edges already passed since the start pulse was driven.
  task automatic finish(input logic [W-1:0] a, input logic [W-1:0] b, input int k0);
    int k = k0;
    logic [63:0] prod = {32'd0, a} * {32'd0, b};
    check("R2 busy after start", 64'(busy_o), 64'(k0 <= W));
    while (!done_o && k < 200) begin
      @(negedge clk);
      k++;
    end
    check("R4 latency", 64'(k), 64'(W + 1));
    check("R5 busy low with done", 64'(busy_o), 64'd0);
    check("R3 product", {hi_o, lo_o}, prod);
  endtask

  task automatic hold_after(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [63:0] prod = {32'd0, a} * {32'd0, b};
    @(negedge clk);
    check("R5 done single cycle", 64'(done_o), 64'd0);
    for (int i = 0; i < 4; i++) begin
      mcand_i  = mcand_i ^ 32'h5A5A_0F0F;
      mplier_i = mplier_i + 32'd7;
      @(negedge clk);
    end
    check("R6 hold", {hi_o, lo_o}, prod);
  endtask

  task automatic t_basic(input logic [W-1:0] a, input logic [W-1:0] b);
    issue(a, b);
    finish(a, b, 1);
    hold_after(a, b);
  endtask

  task automatic t_ignore_busy();
    issue(32'h1234_5678, 32'h9ABC_DEF0);
    repeat (9) @(negedge clk);
    start_i = 1'b1; mcand_i = 32'd3; mplier_i = 32'd5;  // R7 stray start
    @(negedge clk);
    start_i = 1'b0;
    finish(32'h1234_5678, 32'h9ABC_DEF0, 11);
    hold_after(32'h1234_5678, 32'h9ABC_DEF0);
  endtask

  task automatic t_start_on_done();
    issue(32'd1000, 32'd3000);
    finish(32'd1000, 32'd3000, 1);
    issue(32'hFFFF_FFFF, 32'd2);  // R8: driven in the done cycle
    check("R8 accepted in done cycle", 64'(busy_o), 64'd1);
    finish(32'hFFFF_FFFF, 32'd2, 1);
    hold_after(32'hFFFF_FFFF, 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy reset", 64'(busy_o), 64'd0);
    check("R1 done reset", 64'(done_o), 64'd0);
    check("R1 product reset", {hi_o, lo_o}, 64'd0);
    t_basic(32'd6, 32'd7);
    t_basic(32'd0, 32'hDEAD_BEEF);
    t_basic(32'hCAFE_F00D, 32'd0);
    t_basic(32'd1, 32'h8000_0001);
    t_basic(32'hFFFF_FFFF, 32'hFFFF_FFFF);  // R3 carry retention
    t_basic(32'h8000_0000, 32'h8000_0000);
    t_basic(32'hA5A5_A5A5, 32'h3C3C_3C3C);
    t_ignore_busy();
    t_start_on_done();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule